// File: doc/BRIEF.md
# Dual I/O Fast Read Controller

This block is the host side of a serial flash read. It takes a read request (start address, byte count, continuous flag) and runs one transaction on the flash pins: chip select, serial clock and two bidirectional data lines. The outgoing address and mode byte use both data lines, two bits per clock. The flash then returns data on the same two lines, two bits per clock, and the block packs the pairs into a stream of bytes. The serial clock runs at half the system clock.

The block records whether the flash was left in continuous read mode by the mode byte of the previous read. While that mode is active, a new read leaves out the opcode and starts directly with the address. A separate request sends the mode-exit sequence. That sequence takes the flash out of continuous mode so that an opcode-led command can follow.

Top module: `dio_rd_ctrl`

## Requirements
- R1: After reset, and whenever no transaction is running, `cs_n` is 1, `sclk` is 0, `io_oe` is 2'b00 and `req_ready` is 1.
- R2: `sclk` is high for exactly one `clk` cycle at a time and low for at least one. It is never high while `cs_n` is 1. `io_out` changes only while `sclk` is low, so the flash samples it on the rising edge.
- R3: When continuous mode is not active, a read starts with opcode 0xBB, sent MSB first on `io_out[0]`, one bit per `sclk` rising edge. During these 8 clocks `io_oe` is 2'b01 and `io_out[1]` is 0.
- R4: The 24-bit address follows, then the 8-bit mode byte, over 16 clocks with `io_oe` = 2'b11. Each clock carries one bit pair, most significant pair first. `io_out[1]` carries the odd (upper) bit and `io_out[0]` the even bit.
- R5: The mode byte is 0x20 when `req_cont` was 1 at acceptance and 0x00 otherwise.
- R6: A read that follows a mode byte of 0x20 skips the opcode and begins with the address clocks. A read that follows a mode byte of 0x00, or follows reset, includes the opcode.
- R7: Before the first data clock after the mode byte, `io_oe` goes to 2'b00. Each data byte is built from four pairs sampled on `io_in` during `sclk` high, first pair in bits 7:6, with `io_in[1]` as the upper bit of each pair.
- R8: A read delivers exactly `req_len`+1 bytes, each as a one-cycle `dout_valid` pulse with `dout_data`. `cs_n` rises at the end of the last data clock.
- R9: A mode-exit request drives `cs_n` low for 16 `sclk` clocks with `io_out` = 2'b11 and `io_oe` = 2'b11, and returns no data. The next read includes the opcode.
- R10: If `req_mode_rst` and `req_valid` are both 1 while `req_ready` is 1, the mode-exit sequence is run and the read is dropped.
- R11: Requests presented while `req_ready` is 0 have no effect: no extra transaction starts and the running one is unchanged.
- R12: Between two transactions `cs_n` stays high for at least 2 `clk` cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Read request |
| req_mode_rst | input | 1 | Continuous-mode exit request |
| req_addr | input | ADDR_W | Read start address |
| req_len | input | LEN_W | Byte count minus one |
| req_cont | input | 1 | Leave flash in continuous mode after this read |
| req_ready | output | 1 | Idle, request accepted this cycle if presented |
| dout_valid | output | 1 | Data byte strobe |
| dout_data | output | 8 | Data byte |
| cs_n | output | 1 | Flash chip select, active low |
| sclk | output | 1 | Flash serial clock |
| io_out | output | 2 | Values driven on data lines IO1, IO0 |
| io_oe | output | 2 | Per-line output enable |
| io_in | input | 2 | Values sampled from data lines IO1, IO0 |

## Verification
Assertions check the following on every cycle:
- the idle pin state and clock shape;
- that `sclk` is held low while deselected;
- the output enables in the opcode, mode-exit and data phases;
- the choice between the opcode phase and the address phase at acceptance, given the tracked mode;
- the priority of the mode-exit request;
- that chip select falls only from idle.

Only the bench's flash model can show the remaining behaviour: the bit order on the lines, the mode byte values, the packing of returned data into the correct bytes across address wrap, the byte count, and the effect of the mode byte on the next transaction.

// File: rtl/dio_rd_pkg.sv
package dio_rd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD,
    ST_AM,
    ST_DATA,
    ST_RST,
    ST_END
  } dio_st_e;

  localparam logic [7:0] OPC_DIO_READ = 8'hBB;
  localparam logic [7:0] MODE_KEEP    = 8'h20;
  localparam logic [7:0] MODE_DROP    = 8'h00;
  localparam int         OPC_SLOTS    = 8;
  localparam int         PAIRS_PER_B  = 4;
endpackage

// File: rtl/dio_tx_ser.sv
module dio_tx_ser #(
  parameter int W = 40
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         load_wide,
  input  logic [W-1:0] load_vec,
  input  logic         step,
  input  logic         step_wide,
  output logic [1:0]   pins
);
  logic [W-1:0] sr;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr   <= '0;
      pins <= 2'b00;
    end else if (load) begin
      if (load_wide) begin
        pins <= load_vec[W-1:W-2];
        sr   <= {load_vec[W-3:0], 2'b00};
      end else begin
        pins <= {1'b0, load_vec[W-1]};
        sr   <= {load_vec[W-2:0], 1'b0};
      end
    end else if (step) begin
      if (step_wide) begin
        pins <= sr[W-1:W-2];
        sr   <= {sr[W-3:0], 2'b00};
      end else begin
        pins <= {1'b0, sr[W-1]};
        sr   <= {sr[W-2:0], 1'b0};
      end
    end
  end

  AST_NARROW_IO1_LOW: assert property (@(posedge clk) disable iff (rst)
    (load && !load_wide) |=> (pins[1] == 1'b0)); // R3
endmodule

// File: rtl/dio_rx_pack.sv
module dio_rx_pack #(
  parameter int PAIRS = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       shift,
  input  logic [1:0] pair,
  output logic       byte_valid,
  output logic [7:0] byte_data
);
  localparam int PW = $clog2(PAIRS);
  localparam logic [PW-1:0] LAST = PW'(PAIRS - 1);

  logic [5:0]    acc;
  logic [PW-1:0] npair;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc        <= '0;
      npair      <= '0;
      byte_valid <= 1'b0;
      byte_data  <= '0;
    end else begin
      byte_valid <= 1'b0;
      if (shift) begin
        acc   <= {acc[3:0], pair};
        npair <= npair + 1'b1;
        if (npair == LAST) begin
          byte_valid <= 1'b1;
          byte_data  <= {acc, pair};
        end
      end
    end
  end

  AST_BYTE_AFTER_SHIFT: assert property (@(posedge clk) disable iff (rst)
    byte_valid |-> $past(shift)); // R7
endmodule

// File: rtl/dio_mode_track.sv
module dio_mode_track (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic val,
  input  logic clr,
  output logic active
);
  always_ff @(posedge clk) begin
    if (rst)       active <= 1'b0;
    else if (clr)  active <= 1'b0;
    else if (set)  active <= val;
  end

  AST_ACTIVE_FROM_MODE: assert property (@(posedge clk) disable iff (rst)
    $rose(active) |-> $past(set && val)); // R6
endmodule

// File: rtl/dio_rd_ctrl.sv
module dio_rd_ctrl
  import dio_rd_pkg::*;
#(
  parameter int ADDR_W    = 24,
  parameter int LEN_W     = 8,
  parameter int RST_SLOTS = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_mode_rst,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic              req_cont,
  output logic              req_ready,
  output logic              dout_valid,
  output logic [7:0]        dout_data,
  output logic              cs_n,
  output logic              sclk,
  output logic [1:0]        io_out,
  output logic [1:0]        io_oe,
  input  logic [1:0]        io_in
);
  localparam int AM_BITS  = ADDR_W + 8;
  localparam int AM_SLOTS = AM_BITS / 2;
  localparam int SER_W    = AM_BITS + 8;
  localparam int MAX_SL   = (AM_SLOTS > RST_SLOTS) ? AM_SLOTS : RST_SLOTS;
  localparam int CNT_W    = $clog2(MAX_SL) + 1;
  localparam logic [CNT_W-1:0] OPC_LAST = CNT_W'(OPC_SLOTS - 1);
  localparam logic [CNT_W-1:0] AM_LAST  = CNT_W'(AM_SLOTS - 1);
  localparam logic [CNT_W-1:0] RST_LAST = CNT_W'(RST_SLOTS - 1);

  dio_st_e          st;
  logic             ph;
  logic [CNT_W-1:0] cnt;
  logic [LEN_W-1:0] left;
  logic             keep_next;
  logic             cont_active;

  logic             accept, slot_end;
  logic             ser_load, ser_wide, ser_step, ser_step_wide;
  logic [SER_W-1:0] ser_vec;
  logic [7:0]       mode_byte;
  logic             rx_shift, trk_set, trk_clr;

  assign req_ready = (st == ST_IDLE);
  assign accept    = (st == ST_IDLE) && (req_valid || req_mode_rst);
  assign slot_end  = ph && (st == ST_CMD || st == ST_AM || st == ST_DATA || st == ST_RST);
  assign mode_byte = req_cont ? MODE_KEEP : MODE_DROP;

  always_comb begin
    ser_load = accept;
    ser_wide = 1'b1;
    ser_vec  = '1;
    if (!req_mode_rst) begin
      if (cont_active) begin
        ser_vec = {req_addr, mode_byte, 8'h00};
      end else begin
        ser_wide = 1'b0;
        ser_vec  = {OPC_DIO_READ, req_addr, mode_byte};
      end
    end
  end

  assign ser_step      = slot_end && ((st == ST_CMD) ||
                                      (st == ST_AM  && cnt != AM_LAST) ||
                                      (st == ST_RST && cnt != RST_LAST));
  assign ser_step_wide = (st != ST_CMD) || (cnt == OPC_LAST);
  assign rx_shift      = slot_end && (st == ST_DATA);
  assign trk_set       = slot_end && (st == ST_AM)  && (cnt == AM_LAST);
  assign trk_clr       = slot_end && (st == ST_RST) && (cnt == RST_LAST);

  dio_tx_ser #(.W(SER_W)) u_ser (
    .clk       (clk),
    .rst       (rst),
    .load      (ser_load),
    .load_wide (ser_wide),
    .load_vec  (ser_vec),
    .step      (ser_step),
    .step_wide (ser_step_wide),
    .pins      (io_out)
  );

  dio_rx_pack #(.PAIRS(PAIRS_PER_B)) u_rx (
    .clk        (clk),
    .rst        (rst),
    .shift      (rx_shift),
    .pair       (io_in),
    .byte_valid (dout_valid),
    .byte_data  (dout_data)
  );

  dio_mode_track u_trk (
    .clk    (clk),
    .rst    (rst),
    .set    (trk_set),
    .val    (keep_next),
    .clr    (trk_clr),
    .active (cont_active)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      ph        <= 1'b0;
      cnt       <= '0;
      left      <= '0;
      keep_next <= 1'b0;
      cs_n      <= 1'b1;
      sclk      <= 1'b0;
      io_oe     <= 2'b00;
    end else begin
      case (st)
        ST_IDLE: begin
          if (accept) begin
            cs_n      <= 1'b0;
            ph        <= 1'b0;
            sclk      <= 1'b0;
            cnt       <= '0;
            left      <= req_len;
            keep_next <= req_cont;
            if (req_mode_rst) begin
              st    <= ST_RST;
              io_oe <= 2'b11;
            end else if (cont_active) begin
              st    <= ST_AM;
              io_oe <= 2'b11;
            end else begin
              st    <= ST_CMD;
              io_oe <= 2'b01;
            end
          end
        end
        ST_CMD, ST_AM, ST_DATA, ST_RST: begin
          if (!ph) begin
            sclk <= 1'b1;
            ph   <= 1'b1;
          end else begin
            sclk <= 1'b0;
            ph   <= 1'b0;
            cnt  <= cnt + 1'b1;
            case (st)
              ST_CMD: if (cnt == OPC_LAST) begin
                st    <= ST_AM;
                cnt   <= '0;
                io_oe <= 2'b11;
              end
              ST_AM: if (cnt == AM_LAST) begin
                st    <= ST_DATA;
                cnt   <= '0;
                io_oe <= 2'b00;
              end
              ST_DATA: if (cnt[1:0] == 2'b11) begin
                if (left == '0) begin
                  st   <= ST_END;
                  cs_n <= 1'b1;
                end else begin
                  left <= left - 1'b1;
                end
              end
              ST_RST: if (cnt == RST_LAST) begin
                st    <= ST_END;
                cs_n  <= 1'b1;
                io_oe <= 2'b00;
              end
              default: ;
            endcase
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  AST_IDLE_PINS: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE) |-> (cs_n && !sclk && io_oe == 2'b00)); // R1
  AST_SCLK_PULSE: assert property (@(posedge clk) disable iff (rst)
    sclk |=> !sclk); // R2
  AST_SCLK_GATED: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> !sclk); // R2
  AST_CMD_SINGLE: assert property (@(posedge clk) disable iff (rst)
    (st == ST_CMD) |-> (io_oe == 2'b01 && io_out[1] == 1'b0)); // R3
  AST_OPC_SEND: assert property (@(posedge clk) disable iff (rst)
    (accept && !req_mode_rst && !cont_active) |=> (st == ST_CMD)); // R6
  AST_OPC_SKIP: assert property (@(posedge clk) disable iff (rst)
    (accept && !req_mode_rst && cont_active) |=> (st == ST_AM)); // R6
  AST_DATA_RELEASED: assert property (@(posedge clk) disable iff (rst)
    (st == ST_DATA) |-> (io_oe == 2'b00)); // R7
  AST_BYTE_IN_DATA: assert property (@(posedge clk) disable iff (rst)
    dout_valid |-> $past(st == ST_DATA)); // R8
  AST_EXIT_PINS: assert property (@(posedge clk) disable iff (rst)
    (st == ST_RST) |-> (io_out == 2'b11 && io_oe == 2'b11)); // R9
  AST_EXIT_FIRST: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE && req_mode_rst) |=> (st == ST_RST)); // R10
  AST_START_IDLE: assert property (@(posedge clk) disable iff (rst)
    $fell(cs_n) |-> $past(st == ST_IDLE)); // R11
  AST_DESELECT_GAP: assert property (@(posedge clk) disable iff (rst)
    $rose(cs_n) |=> cs_n); // R12
endmodule

// File: tb/dio_rd_ctrl_bench.sv
module dio_rd_ctrl_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_mode_rst = 1'b0, req_cont = 1'b0;
  logic [23:0] req_addr = '0;
  logic [7:0]  req_len = '0;
  logic        req_ready, dout_valid, cs_n, sclk;
  logic [7:0]  dout_data;
  logic [1:0]  io_out, io_oe;
  logic [1:0]  io_in = 2'b00;

  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  dio_rd_ctrl u_dio_rd_ctrl (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_mode_rst(req_mode_rst),
    .req_addr(req_addr), .req_len(req_len), .req_cont(req_cont),
    .req_ready(req_ready), .dout_valid(dout_valid), .dout_data(dout_data),
    .cs_n(cs_n), .sclk(sclk), .io_out(io_out), .io_oe(io_oe), .io_in(io_in)
  );

  function automatic logic [7:0] mem_byte(logic [23:0] a);
    return a[7:0] ^ {a[12:8], a[23:21]} ^ 8'hC3;
  endfunction

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // flash model
  int          fm_st = 0, fm_cnt = 0, fm_nib = 0;
  logic [7:0]  fm_op = '0;
  logic [31:0] fm_am = '0;
  logic [23:0] fm_ptr = '0;
  bit          fm_cont = 0, obs_opc = 0;
  int          oe_bad = 0, rst_rises = 0, cs_falls = 0;

  always @(negedge cs_n) begin
    if (!rst) begin
      cs_falls++;
      fm_st = fm_cont ? 1 : 0;
      fm_cnt = 0; fm_nib = 0; obs_opc = 0; oe_bad = 0; rst_rises = 0;
    end
  end

  always @(posedge sclk) begin
    if (cs_n === 1'b0) begin
      if (io_out == 2'b11 && io_oe == 2'b11) rst_rises++;
      case (fm_st)
        0: begin
          obs_opc = 1;
          if (io_oe != 2'b01 || io_out[1] != 1'b0) oe_bad++;
          fm_op = {fm_op[6:0], io_out[0]};
          fm_cnt++;
          if (fm_cnt == 8) begin
            fm_st = (fm_op == 8'hBB) ? 1 : 3;
            fm_cnt = 0;
          end
        end
        1: begin
          if (io_oe != 2'b11) oe_bad++;
          fm_am = {fm_am[29:0], io_out};
          fm_cnt++;
          if (fm_cnt == 16) begin
            fm_st = 2;
            fm_cont = (fm_am[5:4] == 2'b10);
            fm_ptr = fm_am[31:8];
            fm_nib = 0;
          end
        end
        2: if (io_oe != 2'b00) oe_bad++;
        default: ;
      endcase
    end
  end

  always @(negedge sclk) begin
    if (cs_n === 1'b0 && fm_st == 2) begin
      logic [7:0] b;
      b = mem_byte(fm_ptr);
      io_in = b[7 - 2 * fm_nib -: 2];
      fm_nib++;
      if (fm_nib == 4) begin
        fm_nib = 0;
        fm_ptr = fm_ptr + 24'd1;
      end
    end
  end

  // output capture and pin monitors
  logic [7:0] cap [0:255];
  int         cap_n = 0;
  logic       prev_sclk = 1'b0;
  logic [1:0] prev_io = 2'b00;
  int         r2_bad = 0, hi_run = 0, min_hi = 1000;

  always @(negedge clk) begin
    if (dout_valid === 1'b1 && cap_n < 256) begin
      cap[cap_n] = dout_data;
      cap_n++;
    end
    if (!rst) begin
      if (sclk && prev_sclk) r2_bad++;
      if (sclk && io_out !== prev_io) r2_bad++;
      if (sclk && cs_n) r2_bad++;
      if (cs_n) hi_run++;
      else begin
        if (hi_run > 0 && hi_run < min_hi) min_hi = hi_run;
        hi_run = 0;
      end
    end
    prev_sclk = sclk;
    prev_io = io_out;
  end

  bit exp_cont = 0;

  task automatic wait_idle();
    @(negedge clk);
    while (!req_ready) @(negedge clk);
  endtask

  task automatic run_read(logic [23:0] addr, int len, bit cont, bit busy_poke);
    int falls0;
    wait_idle();
    cap_n = 0;
    falls0 = cs_falls;
    req_valid = 1; req_addr = addr; req_len = 8'(len); req_cont = cont;
    @(negedge clk);
    req_valid = 0;
    if (busy_poke) begin
      for (int i = 0; i < 30; i++) begin
        req_valid = 1; req_mode_rst = 1; req_addr = ~addr; req_len = 8'd200; req_cont = ~cont;
        @(negedge clk);
      end
      req_valid = 0; req_mode_rst = 0;
    end
    while (!req_ready) @(negedge clk);
    chk(obs_opc == !exp_cont, "R6", "opcode present", obs_opc, !exp_cont);
    if (obs_opc) chk(fm_op == 8'hBB, "R3", "opcode", fm_op, 8'hBB);
    chk(oe_bad == 0, "R3,R4,R7", "line direction errors", oe_bad, 0);
    chk(fm_am[31:8] == addr, "R4", "address", fm_am[31:8], addr);
    chk(fm_am[7:0] == (cont ? 8'h20 : 8'h00), "R5", "mode byte", fm_am[7:0], cont ? 8'h20 : 8'h00);
    chk(cap_n == len + 1, "R8", "byte count", cap_n, len + 1);
    for (int i = 0; i < cap_n && i <= len; i++)
      chk(cap[i] == mem_byte(addr + 24'(i)), "R7", "data byte", cap[i], mem_byte(addr + 24'(i)));
    chk(cs_falls == falls0 + 1, "R11", "transactions started", cs_falls, falls0 + 1);
    exp_cont = cont;
  endtask

  task automatic run_exit(bit with_read);
    wait_idle();
    cap_n = 0;
    req_mode_rst = 1;
    if (with_read) begin
      req_valid = 1; req_addr = 24'h0F0F0F; req_len = 8'd4; req_cont = 1;
    end
    @(negedge clk);
    req_mode_rst = 0; req_valid = 0;
    while (!req_ready) @(negedge clk);
    chk(rst_rises == 16, "R9", "mode-exit clocks", rst_rises, 16);
    chk(cap_n == 0, with_read ? "R10" : "R9", "bytes during exit", cap_n, 0);
    exp_cont = 0;
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL R8 watchdog: actual timeout expected completion");
    report();
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'h5EED1);
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(cs_n == 1 && sclk == 0 && io_oe == 2'b00 && req_ready == 1 && dout_valid == 0,
        "R1", "idle pins", {cs_n, sclk, io_oe, req_ready, dout_valid}, 6'b100010);

    run_read(24'h000010, 3, 1, 0);
    run_read(24'h123456, 2, 1, 0);
    run_read(24'hFFFFFE, 3, 0, 0);
    run_read(24'h00ABCD, 0, 0, 0);
    run_read(24'h555AAA, 1, 1, 0);
    run_exit(0);
    run_read(24'h3C3C3C, 1, 0, 0);
    run_exit(0);
    run_read(24'h800001, 2, 1, 0);
    run_exit(1);
    run_read(24'h7E7E7E, 2, 0, 0);
    run_read(24'h0A0B0C, 15, 1, 1);
    run_read(24'h0A0B0D, 1, 0, 0);

    for (int k = 0; k < 24; k++) begin
      if ($urandom % 6 == 0) run_exit($urandom % 2 == 1);
      else run_read(24'($urandom), int'($urandom % 6), bit'($urandom % 2), 0);
    end

    wait_idle();
    chk(r2_bad == 0, "R2", "clock and setup errors", r2_bad, 0);
    chk(min_hi >= 2, "R12", "min deselect cycles", min_hi, 2);
    report();
    $finish;
  end
endmodule